// File: doc/BRIEF.md
# Direction-Switchable Word Serializer/Deserializer

This block is a single engine that moves one 24-bit parallel word over a one-bit serial link. A direction input selects its mode at run time. When the direction input is high, the block serializes: a strobe captures the parallel word, and the block sends a 26-bit frame, one bit per clock, while it raises a bit-clock enable. When the direction input is low, the block deserializes: it takes serial bits on the cycles its bit-valid input is high, finds the frame boundary, and presents each received word on its parallel outputs together with a one-cycle word clock.

Parallel bits 1 to 20 are shared. They are outputs only in deserializer mode, and the output enable tells the pad ring when to drive them. Bits 21 and 22 are inputs only, and they travel across the link to land on the output-only bits 23 and 24 of the partner. The inverted direction output sets a link partner to the opposite mode, so a pair of these blocks always faces each other correctly.

A frame is sent least-significant bit first. Frame bit 0 is a boundary 1 and frame bit 1 is a boundary 0. Frame bits 2 to 21 carry parallel bits 1 to 20, and frame bits 22 and 23 carry dedicated inputs 21 and 22. Frame bits 24 and 25 are padding.

Top module: `dir_serdes`

## Requirements
- R1: `dirOut` is the logical inverse of `dirIn` at all times, with no clock in the path.
- R2: `parOe` is 1 when `dirIn` is 0 (deserializer mode) and 0 when `dirIn` is 1 (serializer mode).
- R3: In serializer mode, each word is sent as exactly 26 consecutive bits on `serOut`, least-significant bit first: bit 0 = 1, bit 1 = 0, bits 2..21 = `parIn[19:0]`, bits 22..23 = `dedIn[1:0]`, bits 24..25 = padding. `serBitClkEn` is high for exactly those 26 cycles.
- R4: The two padding bits (frame bits 24 and 25) are always sent as 0, and `dedIn[0]` and `dedIn[1]` go to frame bits 22 and 23 in that order.
- R5: A strobe sampled high at a clock edge captures `parIn` and `dedIn` at that edge. If the serializer is idle, `serBitClkEn` rises after the next edge, and the first frame bit is driven in that cycle. Later changes on the parallel inputs do not alter the frame.
- R6: A strobe that arrives while a frame is being sent is held. Its word starts in the cycle right after the last bit of the current frame, with no idle cycle between.
- R7: In deserializer mode, the block looks for the boundary pair (1 then 0, in arrival order) and declares lock when two matches fall exactly 26 valid bits apart. The first word presented is the one that completes the second match, and `rxLocked` goes high in that same cycle.
- R8: On each locked frame, `parOut` takes frame bits 2..21 and `dedOut` takes frame bits 22..23. Frame bits 24..25 are ignored. `wordClk` is high for one cycle after the frame's last bit is sampled, in the same cycle the new outputs first appear.
- R9: If the boundary pair is missing at the expected position while locked, lock is dropped, no `wordClk` is given, and `parOut` and `dedOut` keep their previous values.
- R10: In serializer mode, `dedOut` and `parOut` keep their last received value. After a return to deserializer mode, they change only once lock is found again and a new word is presented.
- R11: Serial bits are taken only on cycles with `serInValid` high, and the boundary is found at any bit offset in the stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirIn | input | 1 | Mode: 1 = serializer, 0 = deserializer |
| dirOut | output | 1 | Inverted `dirIn`, for the link partner |
| strobe | input | 1 | Captures the parallel word in serializer mode |
| parIn | input | 20 | Shared parallel bits 1..20, input side |
| dedIn | input | 2 | Dedicated parallel inputs, bits 21..22 |
| serOut | output | 1 | Serial data out |
| serBitClkEn | output | 1 | High while a frame bit is on `serOut` |
| serIn | input | 1 | Serial data in |
| serInValid | input | 1 | `serIn` carries a bit this cycle |
| parOut | output | 20 | Shared parallel bits 1..20, output side |
| parOe | output | 1 | Output enable for the shared bits |
| dedOut | output | 2 | Dedicated parallel outputs, bits 23..24 |
| wordClk | output | 1 | One-cycle pulse marking a new received word |
| rxLocked | output | 1 | Deserializer frame lock |

## Verification
The serializer is driven with all-zero, all-one, alternating and single-bit words. These separate bit order, field position and stuck-at faults. Back-to-back strobes show whether a held word is sent right after the current frame or is lost.

The deserializer is fed several streams:
- an aligned stream with 1s in the padding bits, which shows that those bits are ignored;
- a stream that starts at an odd bit offset and has gaps in the valid signal, which tests how the boundary is found;
- an all-zero frame while locked, which tests loss of lock and that the outputs hold;
- a mode turnaround, which tests that the dedicated outputs are held until the deserializer locks again.

// File: rtl/serdes_pkg.sv
package serdes_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic txCapture;  // latch parallel word into the holding register
    logic txLoad;     // move held word plus boundary into the shifter
    logic txShift;    // advance the transmit shifter by one bit
    logic rxClear;    // flush the receive window
    logic rxShift;    // take one serial bit into the receive window
    logic rxLatch;    // update the parallel outputs from the window
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_CAND = 2'd1,
    RX_LOCK = 2'd2
  } rxState_e;

endpackage

// File: rtl/serdes_ctrl.sv
module serdes_ctrl
  import serdes_pkg::*;
#(
  parameter int FRAME_W = 26,
  parameter int PAD_W   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dirIn,
  input  logic        strobe,
  input  logic        serInValid,
  input  logic        rxMatch,
  output ctrlStrobe_t strb,
  output logic        txBusy,
  output logic        txPadSlot,
  output logic        rxLocked,
  output logic        wordClk
);

  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] PAD_FIRST = CNT_W'(FRAME_W - PAD_W);

  logic             serMode;
  logic             txPend;
  logic [CNT_W-1:0] txCnt;
  logic             txLast;

  rxState_e         rxState;
  logic [CNT_W-1:0] rxPhase;
  logic             rxAtFrame;

  assign serMode   = dirIn;
  assign txLast    = txBusy && (txCnt == LAST_BIT);
  assign txPadSlot = txBusy && (txCnt >= PAD_FIRST);
  assign rxAtFrame = (rxState != RX_HUNT) && (rxPhase == LAST_BIT);
  assign rxLocked  = (rxState == RX_LOCK);

  always_comb begin
    strb           = '0;
    strb.txCapture = serMode && strobe;
    strb.txLoad    = serMode && txPend && (!txBusy || txLast);
    strb.txShift   = serMode && txBusy;
    strb.rxClear   = serMode;
    strb.rxShift   = !serMode && serInValid;
    strb.rxLatch   = !serMode && serInValid && rxAtFrame && rxMatch;
  end

  // Transmit sequencing: one held word, one word in flight
  always_ff @(posedge clk) begin
    if (!rstN || !serMode) begin
      txPend <= 1'b0;
      txBusy <= 1'b0;
      txCnt  <= '0;
    end else begin
      if (strb.txLoad) begin
        txBusy <= 1'b1;
        txCnt  <= '0;
      end else if (txLast) begin
        txBusy <= 1'b0;
        txCnt  <= '0;
      end else if (txBusy) begin
        txCnt <= txCnt + 1'b1;
      end
      if (strobe)           txPend <= 1'b1;
      else if (strb.txLoad) txPend <= 1'b0;
    end
  end

  // Receive framing: hunt, confirm one frame later, then track
  always_ff @(posedge clk) begin
    if (!rstN || serMode) begin
      rxState <= RX_HUNT;
      rxPhase <= '0;
      wordClk <= 1'b0;
    end else begin
      wordClk <= strb.rxLatch;
      if (serInValid) begin
        case (rxState)
          RX_HUNT: begin
            rxPhase <= '0;
            if (rxMatch) rxState <= RX_CAND;
          end
          default: begin
            if (rxAtFrame) begin
              rxPhase <= '0;
              rxState <= rxMatch ? RX_LOCK : RX_HUNT;
            end else begin
              rxPhase <= rxPhase + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R7: a word clock only ever appears under lock
  p_wclk_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    wordClk |-> rxLocked);

  // R8: word clock is a single-cycle pulse
  p_wclk_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    wordClk |=> !wordClk);

  // R6: a held word follows the finishing frame with no gap
  p_pend_served_r6: assert property (@(posedge clk) disable iff (!rstN)
    (serMode && txPend && txLast) |=> (txBusy && txCnt == '0));

endmodule

// File: rtl/serdes_datapath.sv
module serdes_datapath
  import serdes_pkg::*;
#(
  parameter int SHARED_W = 20,
  parameter int DED_W    = 2,
  parameter int PAD_W    = 2,
  parameter int BND_W    = 2,
  parameter logic [BND_W-1:0] BND_PAT = 2'b01
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [SHARED_W-1:0] parIn,
  input  logic [DED_W-1:0]    dedIn,
  input  logic                serIn,
  output logic                serOut,
  output logic                rxMatch,
  output logic [SHARED_W-1:0] parOut,
  output logic [DED_W-1:0]    dedOut
);

  localparam int DATA_W  = SHARED_W + DED_W + PAD_W;
  localparam int FRAME_W = DATA_W + BND_W;

  logic [DATA_W-1:0]  txWord;
  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] txShiftReg;
  logic [FRAME_W-2:0] rxWin;
  logic [FRAME_W-1:0] nextWin;

  generate
    if (PAD_W > 0) begin : g_pad
      assign txWord = {{PAD_W{1'b0}}, dedIn, parIn};
    end else begin : g_nopad
      assign txWord = {dedIn, parIn};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strb.txCapture) begin
      holdReg <= txWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShiftReg <= '0;
    end else if (strb.txLoad) begin
      txShiftReg <= {holdReg, BND_PAT};
    end else if (strb.txShift) begin
      txShiftReg <= {1'b0, txShiftReg[FRAME_W-1:1]};
    end
  end

  assign serOut = txShiftReg[0];

  // Window including the incoming bit; oldest bit at position 0
  assign nextWin = {serIn, rxWin};
  assign rxMatch = (nextWin[BND_W-1:0] == BND_PAT);

  always_ff @(posedge clk) begin
    if (!rstN || strb.rxClear) begin
      rxWin <= '0;
    end else if (strb.rxShift) begin
      rxWin <= nextWin[FRAME_W-1:1];
    end
  end

  // Padding positions above the dedicated field are never read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      parOut <= '0;
      dedOut <= '0;
    end else if (strb.rxLatch) begin
      parOut <= nextWin[BND_W +: SHARED_W];
      dedOut <= nextWin[BND_W + SHARED_W +: DED_W];
    end
  end

  // R9: outputs move only with a latch strobe
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rxLatch |=> ($stable(parOut) && $stable(dedOut)));

endmodule

// File: rtl/dir_serdes.sv
module dir_serdes
  import serdes_pkg::*;
#(
  parameter int SHARED_W = 20,
  parameter int DED_W    = 2,
  parameter int PAD_W    = 2,
  parameter int BND_W    = 2,
  parameter logic [BND_W-1:0] BND_PAT = 2'b01
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dirIn,
  output logic                dirOut,
  input  logic                strobe,
  input  logic [SHARED_W-1:0] parIn,
  input  logic [DED_W-1:0]    dedIn,
  output logic                serOut,
  output logic                serBitClkEn,
  input  logic                serIn,
  input  logic                serInValid,
  output logic [SHARED_W-1:0] parOut,
  output logic                parOe,
  output logic [DED_W-1:0]    dedOut,
  output logic                wordClk,
  output logic                rxLocked
);

  localparam int FRAME_W = SHARED_W + DED_W + PAD_W + BND_W;

  ctrlStrobe_t strb;
  logic        rxMatch;
  logic        txPadSlot;

  // Turnaround path is purely combinational
  assign dirOut = ~dirIn;
  assign parOe  = ~dirIn;

  serdes_ctrl #(
    .FRAME_W (FRAME_W),
    .PAD_W   (PAD_W)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dirIn      (dirIn),
    .strobe     (strobe),
    .serInValid (serInValid),
    .rxMatch    (rxMatch),
    .strb       (strb),
    .txBusy     (serBitClkEn),
    .txPadSlot  (txPadSlot),
    .rxLocked   (rxLocked),
    .wordClk    (wordClk)
  );

  serdes_datapath #(
    .SHARED_W (SHARED_W),
    .DED_W    (DED_W),
    .PAD_W    (PAD_W),
    .BND_W    (BND_W),
    .BND_PAT  (BND_PAT)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .parIn   (parIn),
    .dedIn   (dedIn),
    .serIn   (serIn),
    .serOut  (serOut),
    .rxMatch (rxMatch),
    .parOut  (parOut),
    .dedOut  (dedOut)
  );

  // R3: every frame opens with the leading boundary bit
  p_first_bnd_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serBitClkEn) |-> (serOut == BND_PAT[0]));

  // R4: padding slots carry zero
  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    txPadSlot |-> !serOut);

  // R10: dedicated outputs frozen while serializing
  p_ded_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dirIn && $past(dirIn)) |-> $stable(dedOut));

endmodule

// File: tb/test_dir_serdes.sv
`timescale 1ns/1ps
module test_dir_serdes;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dirIn = 1'b1;
  logic        dirOut;
  logic        strobe = 1'b0;
  logic [19:0] parIn = '0;
  logic [1:0]  dedIn = '0;
  logic        serOut;
  logic        serBitClkEn;
  logic        serIn = 1'b0;
  logic        serInValid = 1'b0;
  logic [19:0] parOut;
  logic        parOe;
  logic [1:0]  dedOut;
  logic        wordClk;
  logic        rxLocked;

  always #2 clk = ~clk;

  dir_serdes i_dir_serdes (
    .clk(clk), .rstN(rstN), .dirIn(dirIn), .dirOut(dirOut), .strobe(strobe),
    .parIn(parIn), .dedIn(dedIn), .serOut(serOut), .serBitClkEn(serBitClkEn),
    .serIn(serIn), .serInValid(serInValid), .parOut(parOut), .parOe(parOe),
    .dedOut(dedOut), .wordClk(wordClk), .rxLocked(rxLocked)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // {ded[1:0], par[19:0]}
  localparam logic [21:0] VEC [6] = '{
    22'h0_00000, 22'h3_FFFFF, 22'h1_A5A5A,
    22'h2_5A5A5, 22'h0_00001, 22'h2_80000
  };

  int          bitsSent;
  int          wcCount;
  logic [19:0] parLog [8];
  logic [1:0]  dedLog [8];
  int          wcAt   [8];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [25:0] mkFrame(input logic [1:0] pad, input logic [21:0] v,
                                          input logic [1:0] bnd);
    return {pad, v[21:20], v[19:0], bnd};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; strobe = 1'b0; serInValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic txOne(input logic [21:0] v);
    logic [25:0] got;
    bit enOk;
    enOk = 1;
    @(negedge clk);
    parIn = v[19:0]; dedIn = v[21:20]; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0; parIn = ~v[19:0]; dedIn = ~v[21:20];
    chk("R5 idle before load", 64'(serBitClkEn), 64'd0);
    for (int k = 0; k < 26; k++) begin
      @(negedge clk);
      got[k] = serOut;
      if (!serBitClkEn) enOk = 0;
    end
    chk("R3 enable over frame", 64'(enOk), 64'd1);
    chk("R3 frame bits", 64'(got), 64'(mkFrame(2'b00, v, 2'b01)));
    chk("R4 pad zero", 64'(got[25:24]), 64'd0);
    chk("R4 dedicated order", 64'(got[23:22]), 64'(v[21:20]));
    @(negedge clk);
    chk("R3 enable drops", 64'(serBitClkEn), 64'd0);
  endtask

  task automatic rxStep(input logic b, input logic v);
    @(negedge clk);
    if (wordClk) begin
      if (wcCount < 8) begin
        parLog[wcCount] = parOut;
        dedLog[wcCount] = dedOut;
        wcAt[wcCount]   = bitsSent;
      end
      wcCount++;
    end
    serIn = b; serInValid = v;
    if (v) bitsSent++;
  endtask

  task automatic rxFrame(input logic [25:0] f, input bit gaps);
    for (int k = 0; k < 26; k++) begin
      rxStep(f[k], 1'b1);
      if (gaps && (k % 3 == 1)) rxStep(1'b0, 1'b0);
    end
  endtask

  task automatic rxClr();
    bitsSent = 0; wcCount = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    chk("reset serBitClkEn", 64'(serBitClkEn), 64'd0);
    chk("reset wordClk", 64'(wordClk), 64'd0);
    chk("reset rxLocked", 64'(rxLocked), 64'd0);
    chk("reset dedOut", 64'(dedOut), 64'd0);
    chk("reset parOut", 64'(parOut), 64'd0);

    // R1 / R2: turnaround outputs follow dirIn without a clock
    dirIn = 1'b0; #0.5;
    chk("R1 dirOut low dir", 64'(dirOut), 64'd1);
    chk("R2 oe in deser", 64'(parOe), 64'd1);
    dirIn = 1'b1; #0.5;
    chk("R1 dirOut high dir", 64'(dirOut), 64'd0);
    chk("R2 oe in ser", 64'(parOe), 64'd0);

    // R3 R4 R5: table walk through the serializer
    for (int i = 0; i < 6; i++) txOne(VEC[i]);

    // R6: strobe during a frame is held and follows with no gap
    begin
      logic [51:0] got;
      bit enOk;
      enOk = 1;
      @(negedge clk);
      parIn = VEC[2][19:0]; dedIn = VEC[2][21:20]; strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      for (int k = 0; k < 52; k++) begin
        @(negedge clk);
        got[k] = serOut;
        if (!serBitClkEn) enOk = 0;
        if (k == 5) begin
          parIn = VEC[5][19:0]; dedIn = VEC[5][21:20]; strobe = 1'b1;
        end else begin
          strobe = 1'b0;
        end
      end
      chk("R6 continuous enable", 64'(enOk), 64'd1);
      chk("R6 first frame", 64'(got[25:0]), 64'(mkFrame(2'b00, VEC[2], 2'b01)));
      chk("R6 held frame", 64'(got[51:26]), 64'(mkFrame(2'b00, VEC[5], 2'b01)));
      @(negedge clk);
      chk("R6 enable drops", 64'(serBitClkEn), 64'd0);
    end

    // R7 R8: aligned stream with 1s in the padding slots
    doReset();
    dirIn = 1'b0;
    rxClr();
    for (int i = 0; i < 6; i++) rxFrame(mkFrame(2'b11, VEC[i], 2'b01), 1'b0);
    rxStep(1'b0, 1'b0);
    rxStep(1'b0, 1'b0);
    chk("R7 word count", 64'(wcCount), 64'd5);
    chk("R7 first word after second boundary", 64'(wcAt[0]), 64'd52);
    chk("R7 locked", 64'(rxLocked), 64'd1);
    for (int j = 0; j < 5; j++) begin
      chk("R8 parallel word", 64'(parLog[j]), 64'(VEC[j+1][19:0]));
      chk("R8 dedicated, pad ignored", 64'(dedLog[j]), 64'(VEC[j+1][21:20]));
    end
    chk("R8 pulse spacing", 64'(wcAt[4] - wcAt[3]), 64'd26);

    // R9: missing boundary drops lock, outputs hold
    rxClr();
    rxFrame(26'd0, 1'b0);
    rxStep(1'b0, 1'b0);
    chk("R9 no word clock", 64'(wcCount), 64'd0);
    chk("R9 lock dropped", 64'(rxLocked), 64'd0);
    chk("R9 parOut held", 64'(parOut), 64'(VEC[5][19:0]));
    chk("R9 dedOut held", 64'(dedOut), 64'(VEC[5][21:20]));
    rxFrame(mkFrame(2'b00, VEC[2], 2'b01), 1'b0);
    rxFrame(mkFrame(2'b00, VEC[3], 2'b01), 1'b0);
    rxStep(1'b0, 1'b0);
    chk("R9 relock count", 64'(wcCount), 64'd1);
    chk("R9 relock word", 64'(parLog[0]), 64'(VEC[3][19:0]));

    // R11: odd offset and gaps in the valid signal
    doReset();
    dirIn = 1'b0;
    rxClr();
    for (int k = 0; k < 7; k++) rxStep(1'b0, 1'b1);
    rxFrame(mkFrame(2'b00, VEC[4], 2'b01), 1'b1);
    rxFrame(mkFrame(2'b00, VEC[5], 2'b01), 1'b1);
    rxStep(1'b0, 1'b0);
    rxStep(1'b0, 1'b0);
    chk("R11 word count", 64'(wcCount), 64'd1);
    chk("R11 offset lock position", 64'(wcAt[0]), 64'd59);
    chk("R11 word", 64'(parLog[0]), 64'(VEC[5][19:0]));
    chk("R11 dedicated", 64'(dedLog[0]), 64'(VEC[5][21:20]));

    // R10: turnaround keeps the dedicated outputs
    @(negedge clk);
    serInValid = 1'b0; dirIn = 1'b1;
    txOne(VEC[1]);
    chk("R10 dedOut held in ser", 64'(dedOut), 64'(VEC[5][21:20]));
    chk("R10 parOut held in ser", 64'(parOut), 64'(VEC[5][19:0]));
    chk("R2 oe off while ser", 64'(parOe), 64'd0);
    @(negedge clk);
    dirIn = 1'b0;
    rxClr();
    rxFrame(mkFrame(2'b00, VEC[0], 2'b01), 1'b0);
    rxStep(1'b0, 1'b0);
    chk("R10 held before relock", 64'(dedOut), 64'(VEC[5][21:20]));
    chk("R10 no word before relock", 64'(wcCount), 64'd0);
    rxFrame(mkFrame(2'b00, VEC[1], 2'b01), 1'b0);
    rxStep(1'b0, 1'b0);
    chk("R10 updated after relock", 64'(dedOut), 64'(VEC[1][21:20]));
    chk("R10 parOut updated", 64'(parOut), 64'(VEC[1][19:0]));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule